// File: doc/BRIEF.md
# Conversion Status and Control Register

This block is the 8-bit status/control register of an analog-to-digital converter controller. It holds three live bits: a conversion-complete flag, an interrupt enable and a single/scan mode select. It raises an interrupt request while the flag and the enable are both set. The block watches two completion pulses:

- a per-channel "conversion done" pulse;
- a "whole scan done" pulse.

The mode bit picks which of the two pulses sets the flag.

Software clears the flag with a handshake. It must first read the register and see the flag at 1, then write 0 to the flag. A DMA read of the conversion result also clears the flag, but only when the DMA qualifier is low. The enable and mode bits are frozen while the converter's start bit (held in a separate control register) is high.

The remaining bit positions are constant: one reads as 1 and the others read as 0. They ignore writes.

Top module: `cvs_reg`

## Requirements
- R1: After synchronous active-high reset the flag (bit 7), enable (bit 6) and mode (bit 5) are 0, the read value is 0x08, `scan_mode` is 0 and `irq` is 0.
- R2: Bit 3 always reads 1 and bits 4, 2, 1 and 0 always read 0; writes to these positions have no effect.
- R3: With `start_bit` at 0, a write loads bit 6 into the enable and bit 5 into the mode (0 = single, 1 = scan); `scan_mode` shows the mode.
- R4: In single mode a `chan_done` pulse sets the flag in the next cycle; `scan_done` is ignored.
- R5: In scan mode only `scan_done` sets the flag; `chan_done` pulses are ignored.
- R6: A write with bit 7 at 0 clears the flag only if a read returned the flag as 1 since the last write; any write forgets that read.
- R7: Writing 1 to bit 7 never sets the flag and never clears it.
- R8: A cycle with `dma_rd` high and `dma_qual` low clears the flag; with `dma_qual` high the DMA read leaves the flag unchanged.
- R9: When a set event and a valid clear fall in the same cycle, the flag ends up set.
- R10: `irq` is registered: it is 1 in the cycle after one where flag and enable are both 1, and 0 in the cycle after one where either is 0.
- R11: While `start_bit` is 1, writes leave the enable and mode bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | CPU read strobe for this register |
| wr_en | input | 1 | CPU write strobe for this register |
| wr_data | input | 8 | CPU write data |
| chan_done | input | 1 | One channel finished converting (pulse) |
| scan_done | input | 1 | All selected channels finished (pulse) |
| dma_rd | input | 1 | DMA read of the conversion result |
| dma_qual | input | 1 | DMA mode qualifier; clears only when 0 |
| start_bit | input | 1 | Conversion running, from the control register |
| rd_data | output | 8 | Register read value |
| scan_mode | output | 1 | Mode select: 0 single, 1 scan |
| irq | output | 1 | Conversion-end interrupt request |

## Verification
The bench builds the block with its default parameters. These are an 8-bit register with the flag, enable and mode at bits 7, 6 and 5, and a constant-one mask of 0x08. This bit layout is the one the bench's expected read values are written against. Directed tasks cover the following:

- both set paths under each mode;
- the read-then-write-zero handshake, including a write that forgets an earlier read;
- DMA clears with the qualifier both low and high;
- set/clear collisions;
- the one-cycle interrupt latency on both edges;
- the start-bit lock.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  localparam int unsigned CVS_DW        = 8;
  localparam int unsigned CVS_FLAG_POS  = 7;
  localparam int unsigned CVS_IEN_POS   = 6;
  localparam int unsigned CVS_MODE_POS  = 5;
  localparam logic [7:0]  CVS_ONES_MASK = 8'h08;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_SCAN   = 1'b1
  } cvs_mode_e;
endpackage

// File: rtl/cvs_flag.sv
module cvs_flag (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_flag_bit,
  input  logic mode,
  input  logic chan_done,
  input  logic scan_done,
  input  logic dma_rd,
  input  logic dma_qual,
  output logic flag_q
);
  import cvs_pkg::*;

  logic mark_q;
  logic set_ev;
  logic sw_clr;
  logic dma_clr;

  // pick the completion source by mode
  assign set_ev  = (cvs_mode_e'(mode) == MODE_SCAN) ? scan_done : chan_done;
  assign sw_clr  = wr_en && !wr_flag_bit && mark_q;
  assign dma_clr = dma_rd && !dma_qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (set_ev) begin
      flag_q <= 1'b1;  // set wins over any clear
    end else if (sw_clr || dma_clr) begin
      flag_q <= 1'b0;
    end
  end

  // remembers that software has seen the flag at 1
  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q <= 1'b0;
    end else if (wr_en) begin
      mark_q <= 1'b0;
    end else if (rd_en && flag_q) begin
      mark_q <= 1'b1;
    end
  end

  assert_single_set_R4: assert property (@(posedge clk) disable iff (rst)
    (!mode && chan_done) |=> flag_q);

  assert_scan_set_R5: assert property (@(posedge clk) disable iff (rst)
    (mode && scan_done) |=> flag_q);

  assert_scan_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && mode && !scan_done) |=> !flag_q);

  assert_hold_unread_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !mark_q && !(dma_rd && !dma_qual)) |=> flag_q);

  assert_dma_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (dma_rd && !dma_qual && !chan_done && !scan_done) |=> !flag_q);
endmodule

// File: rtl/cvs_ctrl.sv
module cvs_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic start_bit,
  input  logic wr_ien,
  input  logic wr_mode,
  output logic ien_q,
  output logic mode_q
);
  logic load;

  assign load = wr_en && !start_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (load) begin
      ien_q  <= wr_ien;
      mode_q <= wr_mode;
    end
  end

  assert_lock_R11: assert property (@(posedge clk) disable iff (rst)
    start_bit |=> ($stable(ien_q) && $stable(mode_q)));

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !start_bit) |=> (ien_q == $past(wr_ien) && mode_q == $past(wr_mode)));
endmodule

// File: rtl/cvs_irq.sv
module cvs_irq (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  input  logic ien,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag && ien;
  end

  assert_irq_on_R10: assert property (@(posedge clk) disable iff (rst)
    (flag && ien) |=> irq_q);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!flag || !ien) |=> !irq_q);
endmodule

// File: rtl/cvs_reg.sv
module cvs_reg #(
  parameter int unsigned DW        = cvs_pkg::CVS_DW,
  parameter int unsigned FLAG_POS  = cvs_pkg::CVS_FLAG_POS,
  parameter int unsigned IEN_POS   = cvs_pkg::CVS_IEN_POS,
  parameter int unsigned MODE_POS  = cvs_pkg::CVS_MODE_POS,
  parameter logic [DW-1:0] ONES_MASK = DW'(cvs_pkg::CVS_ONES_MASK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          chan_done,
  input  logic          scan_done,
  input  logic          dma_rd,
  input  logic          dma_qual,
  input  logic          start_bit,
  output logic [DW-1:0] rd_data,
  output logic          scan_mode,
  output logic          irq
);
  localparam logic [DW-1:0] LIVE_MASK =
    (DW'(1) << FLAG_POS) | (DW'(1) << IEN_POS) | (DW'(1) << MODE_POS);
  localparam logic [DW-1:0] FIXED_ONES = ONES_MASK & ~LIVE_MASK;

  logic flag_q;
  logic ien_q;
  logic mode_q;

  cvs_flag u_flag (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .wr_flag_bit (wr_data[FLAG_POS]),
    .mode        (mode_q),
    .chan_done   (chan_done),
    .scan_done   (scan_done),
    .dma_rd      (dma_rd),
    .dma_qual    (dma_qual),
    .flag_q      (flag_q)
  );

  cvs_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .start_bit (start_bit),
    .wr_ien    (wr_data[IEN_POS]),
    .wr_mode   (wr_data[MODE_POS]),
    .ien_q     (ien_q),
    .mode_q    (mode_q)
  );

  cvs_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .flag  (flag_q),
    .ien   (ien_q),
    .irq_q (irq)
  );

  // read value assembled bit by bit from flops and constants
  for (genvar i = 0; i < DW; i++) begin : g_rd
    if (i == FLAG_POS) begin : g_flag
      assign rd_data[i] = flag_q;
    end else if (i == IEN_POS) begin : g_ien
      assign rd_data[i] = ien_q;
    end else if (i == MODE_POS) begin : g_mode
      assign rd_data[i] = mode_q;
    end else begin : g_fixed
      assign rd_data[i] = FIXED_ONES[i];
    end
  end

  assign scan_mode = mode_q;

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (rst)
    ((rd_data & ~LIVE_MASK) == FIXED_ONES));

  assert_mode_out_R3: assert property (@(posedge clk) disable iff (rst)
    scan_mode == rd_data[MODE_POS]);
endmodule

// File: tb/test_cvs_reg.sv
module test_cvs_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       chan_done = 1'b0, scan_done = 1'b0;
  logic       dma_rd = 1'b0, dma_qual = 1'b0, start_bit = 1'b0;
  logic [7:0] rd_data;
  logic       scan_mode, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cvs_reg i_cvs_reg (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .chan_done(chan_done), .scan_done(scan_done), .dma_rd(dma_rd),
    .dma_qual(dma_qual), .start_bit(start_bit), .rd_data(rd_data),
    .scan_mode(scan_mode), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic cpu_rd(output logic [7:0] d);
    rd_en = 1'b1;
    d = rd_data;
    step();
    rd_en = 1'b0;
  endtask

  task automatic pulse_chan();
    chan_done = 1'b1; step(); chan_done = 1'b0;
  endtask

  task automatic pulse_scan();
    scan_done = 1'b1; step(); scan_done = 1'b0;
  endtask

  task automatic dma(input logic q);
    dma_rd = 1'b1; dma_qual = q; step(); dma_rd = 1'b0; dma_qual = 1'b0;
  endtask

  task automatic clear_flag(input logic [7:0] keep);
    logic [7:0] d;
    cpu_rd(d);
    cpu_wr(keep & 8'h60);
  endtask

  task automatic t_reset();
    check("R1 read", rd_data, 8'h08);
    check("R1 scan_mode", {7'd0, scan_mode}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_fixed();
    cpu_wr(8'h17);
    check("R2 fixed bits", rd_data, 8'h08);
  endtask

  task automatic t_ctrl();
    cpu_wr(8'h60);
    check("R3 load", rd_data, 8'h68);
    check("R3 scan_mode", {7'd0, scan_mode}, 8'h01);
    cpu_wr(8'h00);
    check("R3 reload", rd_data, 8'h08);
  endtask

  task automatic t_single();
    pulse_scan();
    check("R4 scan_done ignored", rd_data, 8'h08);
    pulse_chan();
    check("R4 set", rd_data, 8'h88);
  endtask

  task automatic t_handshake();
    logic [7:0] d;
    cpu_wr(8'h00);
    check("R6 no read", rd_data, 8'h88);
    cpu_rd(d);
    check("R6 read value", d, 8'h88);
    cpu_wr(8'h80);
    check("R7 write one", rd_data, 8'h88);
    cpu_wr(8'h00);
    check("R6 mark dropped", rd_data, 8'h88);
    cpu_rd(d);
    cpu_wr(8'h00);
    check("R6 clear", rd_data, 8'h08);
    cpu_wr(8'h80);
    check("R7 no set", rd_data, 8'h08);
  endtask

  task automatic t_scan();
    cpu_wr(8'h20);
    pulse_chan();
    check("R5 chan ignored", rd_data, 8'h28);
    pulse_scan();
    check("R5 set", rd_data, 8'hA8);
    dma(1'b1);
    check("R8 qual high", rd_data, 8'hA8);
    dma(1'b0);
    check("R8 clear", rd_data, 8'h28);
    cpu_wr(8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    pulse_chan();
    cpu_rd(d);
    chan_done = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
    step();
    chan_done = 1'b0; wr_en = 1'b0;
    check("R9 sw clear collision", rd_data, 8'h88);
    chan_done = 1'b1; dma_rd = 1'b1; dma_qual = 1'b0;
    step();
    chan_done = 1'b0; dma_rd = 1'b0;
    check("R9 dma collision", rd_data, 8'h88);
    dma(1'b0);
    check("R8 clear after", rd_data, 8'h08);
  endtask

  task automatic t_irq();
    cpu_wr(8'h40);
    chan_done = 1'b1;
    step();              // flag set at this edge
    chan_done = 1'b0;
    check("R10 lag", {7'd0, irq}, 8'h00);
    step();
    check("R10 rise", {7'd0, irq}, 8'h01);
    dma(1'b0);           // flag clears at this edge
    check("R10 hold", {7'd0, irq}, 8'h01);
    step();
    check("R10 fall", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_lock();
    start_bit = 1'b1;
    cpu_wr(8'h20);
    check("R11 locked", rd_data, 8'h48);
    check("R11 scan_mode", {7'd0, scan_mode}, 8'h00);
    start_bit = 1'b0;
    cpu_wr(8'h00);
    check("R11 unlocked", rd_data, 8'h08);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_fixed();
    t_ctrl();
    t_single();
    t_handshake();
    t_scan();
    t_set_wins();
    t_irq();
    t_lock();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule